// File: doc/BRIEF.md
# Self-Invalidating Valid/Private L1 Data Cache Controller

This block is the state and write-policy engine of one core's L1 data cache in a coherence scheme that has no directory and sends no invalidations. Every line holds two independent attributes: whether it is valid, and whether it belongs to private or shared data. The shared/private class arrives with each request from an outside page classifier and is fixed into the line when it is filled. Stores to private lines stay in the cache and go to memory only when the line is evicted, and then the whole line is written. Stores to shared lines set a dirty bit for each word they touch. Those words go to memory later as a partial write that carries only the marked words.

A synchronization request makes the controller give up its shared copies. It first walks all lines in index order and writes out the dirty words of each shared line. It then clears the valid bit of every shared line in one step, and only after that does it report completion. Private lines are left as they are. A spin request lets a core wait in its own cache for a value to change. While the cached word still equals the compare value, the controller drops the line and fetches it again from memory, so a write from another core becomes visible.

The core port uses a hold-until-done handshake. The memory port carries line reads and masked line writes under a valid/ready handshake, and fill data comes back on a separate valid strobe.

Top module: `vips_l1_ctrl`

## Requirements
- R1: A load that hits returns the addressed word on `core_rdata`. `core_done` is high for exactly one cycle, in the second cycle after the request is seen, and the hit makes no memory traffic.
- R2: On a miss, a valid victim with any dirty word is written out first. After that a read of the requested line address is issued. The line is filled from `mem_rdata`, where word w sits at bits [w*32 +: 32]. It takes the request's `core_shared` value as its class and has all dirty bits clear.
- R3: A store to a private line causes no memory traffic. When a dirty private line is evicted it is written out with `mem_wmask` all ones.
- R4: A store to a shared line marks only the written word dirty and causes no memory traffic. When that line is evicted, `mem_wmask` bit w is set exactly for the dirty words.
- R5: A sync request (`core_op`=2) issues one write per shared line that has dirty words, in increasing line index order, with the dirty-word mask. It issues no reads. Afterwards no shared line is valid, so the next access to a shared address misses.
- R6: A sync leaves private lines valid and dirty. It issues no write for them, and a later load to them hits.
- R7: Dirty bits clear when the memory port accepts the write, so a second sync with no stores in between makes no memory traffic. No write ever has an all-zero mask.
- R8: A spin request (`core_op`=3) completes with the word once the word differs from `core_wdata`. While the word equals `core_wdata`, the line is dropped and read again from memory until a remote update shows up.
- R9: A memory request held without `mem_ready` keeps `mem_valid`, `mem_we`, `mem_addr` and `mem_wmask` unchanged until it is accepted.
- R10: After reset all lines are invalid and `core_done` and `mem_valid` are low. Op codes are 0 load, 1 store, 2 sync, 3 spin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_valid | input | 1 | Core request present, held until `core_done` |
| core_op | input | 2 | 0 load, 1 store, 2 sync, 3 spin |
| core_addr | input | 12 | Word address: offset in bits [1:0], line index in bits [3:2], tag above |
| core_wdata | input | 32 | Store data, or compare value for spin |
| core_shared | input | 1 | Page class of the address, 1 = shared |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | 32 | Loaded or spun-on word |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = masked line write, 0 = line read |
| mem_addr | output | 10 | Line address |
| mem_wmask | output | 4 | Per-word write enable |
| mem_wdata | output | 128 | Line write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Fill data valid |
| mem_rdata | input | 128 | Fill line data |

## Verification
The bench aims at the sync ordering. A controller that invalidated before writing, or wrote out private lines, would lose shared stores or show extra writes, and the next shared load would bring back stale data. It evicts both kinds of dirty line to catch a mask that is full for shared data or partial for private data. It also runs a sync twice to catch dirty bits that never clear. The spin case puts the remote update only on the second refetch, so a controller that spins on its stale copy never completes and one that refetches just once returns the wrong word. A stalling `mem_ready` exposes requests that move before they are accepted.

// File: rtl/vips_pkg.sv
package vips_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_SYNC  = 2'd2,
        OP_SPIN  = 2'd3
    } core_op_e;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_EVICT     = 3'd1,
        S_FILL_REQ  = 3'd2,
        S_FILL_WAIT = 3'd3,
        S_SYNC      = 3'd4,
        S_SYNC_INV  = 3'd5,
        S_RESP      = 3'd6
    } ctl_state_e;

endpackage

// File: rtl/vips_word_merge.sv
module vips_word_merge #(
    parameter int WORDS = 4,
    parameter int DW    = 32
) (
    input  logic [WORDS*DW-1:0]         line_i,
    input  logic [$clog2(WORDS)-1:0]    sel_i,
    input  logic [DW-1:0]               word_i,
    output logic [WORDS*DW-1:0]         line_o
);
    localparam int OFFW = $clog2(WORDS);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign line_o[w*DW +: DW] = (sel_i == OFFW'(w)) ? word_i : line_i[w*DW +: DW];
    end

endmodule

// File: rtl/vips_line_mask.sv
module vips_line_mask #(
    parameter int WORDS = 4
) (
    input  logic             shared_i,
    input  logic [WORDS-1:0] dirty_i,
    output logic [WORDS-1:0] mask_o
);
    // shared data goes out word by word, private data as a whole line
    assign mask_o = shared_i ? dirty_i : {WORDS{|dirty_i}};

endmodule

// File: rtl/vips_l1_ctrl.sv
module vips_l1_ctrl #(
    parameter int NLINES = 4,
    parameter int WORDS  = 4,
    parameter int DW     = 32,
    parameter int AW     = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      core_valid,
    input  logic [1:0]                core_op,
    input  logic [AW-1:0]             core_addr,
    input  logic [DW-1:0]             core_wdata,
    input  logic                      core_shared,
    output logic                      core_done,
    output logic [DW-1:0]             core_rdata,
    output logic                      mem_valid,
    output logic                      mem_we,
    output logic [AW-$clog2(WORDS)-1:0] mem_addr,
    output logic [WORDS-1:0]          mem_wmask,
    output logic [WORDS*DW-1:0]       mem_wdata,
    input  logic                      mem_ready,
    input  logic                      mem_rvalid,
    input  logic [WORDS*DW-1:0]       mem_rdata
);
    import vips_pkg::*;

    localparam int OFFW  = $clog2(WORDS);
    localparam int IDXW  = $clog2(NLINES);
    localparam int LAW   = AW - OFFW;
    localparam int TAGW  = LAW - IDXW;
    localparam int LINEW = WORDS * DW;

    typedef struct packed {
        ctl_state_e                          st;
        logic [IDXW-1:0]                     scan;
        logic                                done;
        logic [DW-1:0]                       rdata;
        logic [NLINES-1:0]                   valid;
        logic [NLINES-1:0]                   shared;
        logic [NLINES-1:0][TAGW-1:0]         tag;
        logic [NLINES-1:0][WORDS-1:0]        dirty;
        logic [NLINES-1:0][WORDS-1:0][DW-1:0] data;
    } ctl_t;

    ctl_t q, d;

    // request decode
    core_op_e          op;
    logic [OFFW-1:0]   roff;
    logic [IDXW-1:0]   ridx;
    logic [TAGW-1:0]   rtag;
    logic [LAW-1:0]    req_la;
    logic              hit;
    logic [DW-1:0]     cur_word;
    logic [LINEW-1:0]  merged;

    assign op       = core_op_e'(core_op);
    assign roff     = core_addr[OFFW-1:0];
    assign ridx     = core_addr[OFFW +: IDXW];
    assign rtag     = core_addr[AW-1 -: TAGW];
    assign req_la   = core_addr[AW-1:OFFW];
    assign hit      = q.valid[ridx] && (q.tag[ridx] == rtag);
    assign cur_word = q.data[ridx][roff];

    vips_word_merge #(.WORDS(WORDS), .DW(DW)) u_merge (
        .line_i (q.data[ridx]),
        .sel_i  (roff),
        .word_i (core_wdata),
        .line_o (merged)
    );

    // per-line write masks and sync work flags
    logic [NLINES-1:0][WORDS-1:0] lmask;
    logic [NLINES-1:0]            sync_need;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        vips_line_mask #(.WORDS(WORDS)) u_mask (
            .shared_i (q.shared[i]),
            .dirty_i  (q.dirty[i]),
            .mask_o   (lmask[i])
        );
        assign sync_need[i] = q.valid[i] & q.shared[i] & (|q.dirty[i]);
    end

    logic last_scan;
    assign last_scan = (q.scan == IDXW'(NLINES - 1));

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wmask = '0;
        mem_wdata = '0;

        case (q.st)
            S_IDLE: begin
                if (core_valid) begin
                    if (op == OP_SYNC) begin
                        d.scan = '0;
                        d.st   = S_SYNC;
                    end else if (hit && !(op == OP_SPIN && cur_word == core_wdata)) begin
                        if (op == OP_STORE) begin
                            d.data[ridx]        = merged;
                            d.dirty[ridx][roff] = 1'b1;
                        end
                        d.rdata = cur_word;
                        d.done  = 1'b1;
                        d.st    = S_RESP;
                    end else begin
                        // miss, or a spin still seeing the old value: drop and refetch
                        d.st = (q.valid[ridx] && (|q.dirty[ridx])) ? S_EVICT : S_FILL_REQ;
                    end
                end
            end

            S_EVICT: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {q.tag[ridx], ridx};
                mem_wmask = lmask[ridx];
                mem_wdata = q.data[ridx];
                if (mem_ready) begin
                    d.dirty[ridx] = '0;
                    d.valid[ridx] = 1'b0;
                    d.st          = S_FILL_REQ;
                end
            end

            S_FILL_REQ: begin
                mem_valid = 1'b1;
                mem_addr  = req_la;
                if (mem_ready) begin
                    d.st = S_FILL_WAIT;
                end
            end

            S_FILL_WAIT: begin
                if (mem_rvalid) begin
                    d.data[ridx]   = mem_rdata;
                    d.valid[ridx]  = 1'b1;
                    d.tag[ridx]    = rtag;
                    d.shared[ridx] = core_shared;
                    d.dirty[ridx]  = '0;
                    d.st           = S_IDLE;
                end
            end

            S_SYNC: begin
                if (sync_need[q.scan]) begin
                    mem_valid = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = {q.tag[q.scan], q.scan};
                    mem_wmask = lmask[q.scan];
                    mem_wdata = q.data[q.scan];
                    if (mem_ready) begin
                        d.dirty[q.scan] = '0;
                        d.scan          = q.scan + 1'b1;
                        d.st            = last_scan ? S_SYNC_INV : S_SYNC;
                    end
                end else begin
                    d.scan = q.scan + 1'b1;
                    d.st   = last_scan ? S_SYNC_INV : S_SYNC;
                end
            end

            S_SYNC_INV: begin
                d.valid = q.valid & ~q.shared;
                d.done  = 1'b1;
                d.st    = S_RESP;
            end

            S_RESP: begin
                d.st = S_IDLE;
            end

            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign core_done  = q.done;
    assign core_rdata = q.rdata;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> !core_done);                                         // R1

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we)
            && $stable(mem_addr) && $stable(mem_wmask)));                   // R9

    AST_WMASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> (mem_wmask != '0));                       // R7

    AST_SYNC_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_SYNC && mem_valid) |-> mem_we);                          // R5

    AST_SHARED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_SYNC_INV) |=> ((q.valid & q.shared) == '0));             // R5

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |-> !mem_valid);                                          // R1

endmodule

// File: tb/vips_l1_ctrl_tb.sv
module vips_l1_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         core_valid = 1'b0;
    logic [1:0]   core_op = '0;
    logic [11:0]  core_addr = '0;
    logic [31:0]  core_wdata = '0;
    logic         core_shared = 1'b0;
    logic         core_done;
    logic [31:0]  core_rdata;
    logic         mem_valid;
    logic         mem_we;
    logic [9:0]   mem_addr;
    logic [3:0]   mem_wmask;
    logic [127:0] mem_wdata;
    logic         mem_ready = 1'b0;
    logic         mem_rvalid = 1'b0;
    logic [127:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vips_l1_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .core_valid(core_valid), .core_op(core_op), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_shared(core_shared),
        .core_done(core_done), .core_rdata(core_rdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wmask(mem_wmask), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memories: smem serves the design, gmem follows the reference model
    logic [31:0] smem [int];
    logic [31:0] gmem [int];

    function automatic logic [31:0] dflt(input int a);
        return 32'(a * 7 + 100);
    endfunction

    function automatic logic [31:0] srd(input int a);
        return smem.exists(a) ? smem[a] : dflt(a);
    endfunction

    function automatic logic [31:0] grd(input int a);
        return gmem.exists(a) ? gmem[a] : dflt(a);
    endfunction

    typedef struct {
        bit          we;
        int          la;
        bit [3:0]    mask;
        logic [127:0] data;
        string       req;
    } tr_t;

    tr_t expq[$];

    // reference cache state
    bit          mv [4];
    bit          ms [4];
    int          mt [4];
    bit [3:0]    md [4];
    logic [31:0] mdat [4][4];

    // memory responder state
    int  cyc = 0;
    bit  rd_pend = 0;
    int  rd_wait = 0;
    int  rd_la = 0;
    bit  spin_mode = 0;
    int  spin_reads = 0;
    int  remote_a = 0;
    logic [31:0] remote_v = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            mem_ready  = (cyc % 3) != 1;
            mem_rvalid = 1'b0;
            if (rd_pend) begin
                if (rd_wait == 0) begin
                    for (int w = 0; w < 4; w++) mem_rdata[w*32 +: 32] = srd(rd_la*4 + w);
                    mem_rvalid = 1'b1;
                    rd_pend    = 0;
                end else begin
                    rd_wait--;
                end
            end
            if (mem_valid && mem_ready) begin
                if (!mem_we) begin
                    if (spin_mode) begin
                        spin_reads++;
                        if (spin_reads == 2) smem[remote_a] = remote_v;
                    end
                    rd_pend = 1;
                    rd_wait = 2;
                    rd_la   = int'(mem_addr);
                end else begin
                    for (int w = 0; w < 4; w++)
                        if (mem_wmask[w]) smem[int'(mem_addr)*4 + w] = mem_wdata[w*32 +: 32];
                end
                if (!spin_mode) begin
                    if (expq.size() == 0) begin
                        chk(0, "R3", "unexpected memory request addr", 128'(mem_addr), 128'h0);
                    end else begin
                        tr_t e;
                        bit dok;
                        e = expq.pop_front();
                        chk(mem_we == e.we, e.req, "request kind", 128'(mem_we), 128'(e.we));
                        chk(int'(mem_addr) == e.la, e.req, "line address", 128'(mem_addr), 128'(e.la));
                        if (e.we) begin
                            chk(mem_wmask == e.mask, e.req, "write mask", 128'(mem_wmask), 128'(e.mask));
                            dok = 1;
                            for (int w = 0; w < 4; w++)
                                if (e.mask[w] && mem_wdata[w*32 +: 32] !== e.data[w*32 +: 32]) dok = 0;
                            chk(dok, e.req, "write data", mem_wdata, e.data);
                        end
                    end
                end
            end
        end
    end

    function automatic int f_idx(input int a); return (a >> 2) & 3; endfunction
    function automatic int f_off(input int a); return a & 3; endfunction
    function automatic int f_tag(input int a); return a >> 4; endfunction
    function automatic bit f_cls(input int a); return bit'((a >> 5) & 1); endfunction

    function automatic logic [127:0] mline(input int i);
        logic [127:0] l;
        for (int w = 0; w < 4; w++) l[w*32 +: 32] = mdat[i][w];
        return l;
    endfunction

    task automatic model_miss(input int a, input string req);
        int i;
        tr_t t;
        i = f_idx(a);
        if (mv[i] && md[i] != 0) begin
            t.we   = 1;
            t.la   = mt[i]*4 + i;
            t.mask = ms[i] ? md[i] : 4'hf;
            t.data = mline(i);
            t.req  = req;
            expq.push_back(t);
            for (int w = 0; w < 4; w++) if (t.mask[w]) gmem[t.la*4 + w] = mdat[i][w];
        end
        t.we = 0; t.la = a >> 2; t.mask = 0; t.data = '0; t.req = req;
        expq.push_back(t);
        for (int w = 0; w < 4; w++) mdat[i][w] = grd((a >> 2)*4 + w);
        mv[i] = 1; mt[i] = f_tag(a); ms[i] = f_cls(a); md[i] = 0;
    endtask

    task automatic model_sync(input string req);
        tr_t t;
        for (int i = 0; i < 4; i++) begin
            if (mv[i] && ms[i] && md[i] != 0) begin
                t.we = 1; t.la = mt[i]*4 + i; t.mask = md[i]; t.data = mline(i); t.req = req;
                expq.push_back(t);
                for (int w = 0; w < 4; w++) if (md[i][w]) gmem[t.la*4 + w] = mdat[i][w];
                md[i] = 0;
            end
        end
        for (int i = 0; i < 4; i++) if (ms[i]) mv[i] = 0;
    endtask

    task automatic issue(input logic [1:0] op, input int a, input logic [31:0] wd);
        @(negedge clk);
        core_valid  = 1'b1;
        core_op     = op;
        core_addr   = 12'(a);
        core_wdata  = wd;
        core_shared = f_cls(a);
        do @(negedge clk); while (!core_done);
        core_valid = 1'b0;
    endtask

    // op: 0 load, 1 store, 2 sync
    task automatic req(input logic [1:0] op, input int a, input logic [31:0] wd, input string tag);
        int i;
        logic [31:0] exp;
        i = f_idx(a);
        exp = '0;
        if (op == 2'd2) begin
            model_sync(tag);
        end else begin
            if (!(mv[i] && mt[i] == f_tag(a))) model_miss(a, tag);
            exp = mdat[i][f_off(a)];
            if (op == 2'd1) begin
                mdat[i][f_off(a)] = wd;
                md[i][f_off(a)]   = 1;
            end
        end
        issue(op, a, wd);
        if (op == 2'd0) chk(core_rdata == exp, tag, "load data", 128'(core_rdata), 128'(exp));
        chk(expq.size() == 0, tag, "missing memory requests", 128'(expq.size()), 128'h0);
        expq.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R10", "watchdog expired", 128'h0, 128'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(core_done == 1'b0, "R10", "done after reset", 128'(core_done), 128'h0);
        chk(mem_valid == 1'b0, "R10", "mem_valid after reset", 128'(mem_valid), 128'h0);

        // R2: first access misses and fills; R1: repeat hits silently
        req(2'd0, 12'h010, '0, "R2");
        req(2'd0, 12'h010, '0, "R1");
        // R3: private store stays local
        req(2'd1, 12'h011, 32'h1111_0001, "R3");
        req(2'd0, 12'h011, '0, "R1");
        // R4: shared line stores mark words only
        req(2'd0, 12'h025, '0, "R2");
        req(2'd1, 12'h026, 32'h2222_0002, "R4");
        req(2'd1, 12'h027, 32'h2222_0003, "R4");
        // R5: sync writes dirty shared words, keeps private dirty line
        req(2'd2, 0, '0, "R5");
        req(2'd0, 12'h011, '0, "R6");
        req(2'd0, 12'h026, '0, "R5");
        // R7: second sync is silent
        req(2'd2, 0, '0, "R7");
        // R3: dirty private eviction writes full line
        req(2'd0, 12'h021, '0, "R3");
        // R4: dirty shared eviction writes only marked word
        req(2'd1, 12'h025, 32'h3333_0004, "R4");
        req(2'd0, 12'h035, '0, "R4");

        // R8: spin on an unchanged value until a remote write lands
        begin
            int a;
            logic [31:0] oldv;
            a = 12'h0a4;
            req(2'd0, a, '0, "R8");
            oldv       = mdat[f_idx(a)][f_off(a)];
            remote_a   = a;
            remote_v   = 32'hCAFE_0001;
            spin_reads = 0;
            spin_mode  = 1;
            issue(2'd3, a, oldv);
            spin_mode  = 0;
            chk(core_rdata == remote_v, "R8", "spin result", 128'(core_rdata), 128'(remote_v));
            chk(spin_reads >= 2, "R8", "spin refetch count", 128'(spin_reads), 128'h2);
            gmem[a] = remote_v;
            for (int w = 0; w < 4; w++) mdat[f_idx(a)][w] = grd((a >> 2)*4 + w);
            md[f_idx(a)] = 0;
            // R8: spin on a differing value returns at once, no traffic
            req(2'd0, a, '0, "R8");
            issue(2'd3, a, oldv);
            chk(core_rdata == remote_v, "R8", "spin immediate", 128'(core_rdata), 128'(remote_v));
            chk(expq.size() == 0, "R8", "spin traffic", 128'(expq.size()), 128'h0);
        end

        // R9 and mixed traffic under a stalling memory port
        for (int k = 0; k < 300; k++) begin
            int a;
            int r;
            a = int'($urandom_range(0, 255));
            r = int'($urandom_range(0, 9));
            if (r < 5)      req(2'd0, a, '0, "R9");
            else if (r < 9) req(2'd1, a, $urandom, "R9");
            else            req(2'd2, 0, '0, "R5");
        end
        req(2'd2, 0, '0, "R5");
        for (int a = 0; a < 256; a += 13) req(2'd0, a, '0, "R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule